// File: doc/BRIEF.md
# DRAM PHY Initialization Step Sequencer

This block is the control half of a DRAM PHY bring-up engine. Software writes a 32-bit trigger word that names a set of initialization and training steps. The sequencer runs the chosen steps one at a time, always in the same hardware order, whatever order the request bits were set in. It reports a done flag for every step, an error flag for the steps that can fail, and a global completion flag in a 32-bit status word. Each step is carried out by a stub timing engine that takes `STEP_LAT` cycles (1 to 256). Its pass or fail result comes from the `err_inject` input, so the sequencing logic can be tested without the analog hardware.

A second, independent function guards the voltage/temperature (VT) compensation updates. The PHY runs a short update every `VT_PERIOD` cycles. When `vt_inhibit` is raised, any update already in progress is allowed to complete, and `vt_stop` then acknowledges that the delay lines are frozen. Dropping `vt_inhibit` releases `vt_stop` on the next edge.

Step index order (also the execution priority): 0 PLL, 1 delay-line calibration, 2 impedance calibration, 3 DRAM init, 4 write leveling, 5 read gate training, 6 write-leveling adjust, 7 read deskew, 8 write deskew, 9 read eye, 10 write eye.

The sequencer has three states:
- SQ_IDLE waits for a trigger.
- SQ_SCAN picks the lowest pending step.
- SQ_RUN waits for the step timer.

Its transitions are:
- IDLE→SCAN on an accepted trigger.
- SCAN→IDLE when nothing is pending; this sets global done.
- SCAN→SCAN when the picked step is bypassed.
- SCAN→RUN when the picked step starts its timer.
- RUN→SCAN when the timer fires.

Top module: `phy_init_seq`

## Requirements
- R1: A trigger write is accepted only when `trig_data[0]` is 1 and the block is idle (`busy`=0). Writes while busy, and writes with bit 0 clear, change nothing.
- R2: The request decode is as follows. Bit 4 or bit 6 requests PLL. Bit 5 requests delay-line calibration. Bit 1 requests impedance calibration. Bit 7 or bit 8 requests DRAM init. Bits 9..15 request, in turn, write leveling, gate training, write-leveling adjust, read deskew, write deskew, read eye and write eye.
- R3: Requested steps run strictly in step-index order. Each step's done flag rises `STEP_LAT`+1 cycles after the previous step's done flag, or after the accepting edge for the first step.
- R4: Status bit 1+k is the done flag of step k, for k = 0..10.
- R5: A step that has an error flag and finishes with `err_inject[k]`=1 sets both its done flag and its error flag. Impedance calibration uses error bit 20, and the training steps k = 4..10 use error bits 17+k. PLL, delay-line calibration and DRAM init never set an error. Steps after a failure still run.
- R6: Status bit 0 is set on the same edge on which `busy` falls, after every requested step has set its done flag.
- R7: An accepted trigger clears bit 0 and clears the done and error flags of the requested steps only. All other flags keep their values.
- R8: Trigger bit 30 makes a requested impedance calibration complete at once with its done flag set and no error.
- R9: Trigger bit 31 makes every requested step complete at once with its done flag set and no error.
- R10: While `vt_inhibit` is 1, no VT update starts. `vt_stop` rises only once any update in progress has finished, and `vt_stop` and `vt_updating` are never 1 together.
- R11: One edge after `vt_inhibit` returns to 0, `vt_stop` is 0.
- R12: After reset, `status` is 0, `busy` is 0 and `vt_stop` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_we | input | 1 | Trigger word write strobe |
| trig_data | input | 32 | Trigger word: start, step requests, bypass bits |
| err_inject | input | 11 | Per-step failure result for the stub engines, indexed by step |
| vt_inhibit | input | 1 | Request to freeze VT compensation |
| status | output | 32 | Global done, per-step done and error flags |
| busy | output | 1 | Sequence in progress |
| vt_stop | output | 1 | VT compensation frozen acknowledge |
| vt_updating | output | 1 | A VT update is in progress |

## Verification
The assertions assume three things about the inputs: `vt_inhibit` and `trig_we` change only between clock edges, `err_inject` is stable while a step is running, and software reads the status only after `busy` has fallen. The stimulus meets these assumptions. Every input is driven on the falling edge. `err_inject` is set before each trigger and is left unchanged until the sequence finishes. The run that tests a write during a busy sequence changes only `trig_we` and `trig_data`. The VT checks raise `vt_inhibit` once in the middle of an update and once while the PHY is quiet, so both paths to `vt_stop` are exercised.

// File: rtl/phy_init_seq_pkg.sv
package phy_init_seq_pkg;
    localparam int NSTEP = 11;
    localparam int IDXW  = $clog2(NSTEP);
    localparam int NERR  = 8;

    localparam logic [IDXW-1:0] ST_PLL  = 4'd0;
    localparam logic [IDXW-1:0] ST_DCAL = 4'd1;
    localparam logic [IDXW-1:0] ST_ZCAL = 4'd2;
    localparam logic [IDXW-1:0] ST_DRAM = 4'd3;
    localparam logic [IDXW-1:0] ST_WL   = 4'd4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_RUN  = 2'd2
    } seq_state_t;

    // Trigger word to per-step request mask, in execution order.
    function automatic logic [NSTEP-1:0] decode_req(input logic [31:0] t);
        logic [NSTEP-1:0] r;
        r[0]    = t[4] | t[6];
        r[1]    = t[5];
        r[2]    = t[1];
        r[3]    = t[7] | t[8];
        r[10:4] = t[15:9];
        return r;
    endfunction

    // Steps that own an error flag, packed into the error field order.
    function automatic logic [NERR-1:0] err_mask(input logic [NSTEP-1:0] r);
        return {r[10:4], r[2]};
    endfunction
endpackage

// File: rtl/step_pick.sv
module step_pick
    import phy_init_seq_pkg::*;
(
    input  logic [NSTEP-1:0] req,
    output logic             any,
    output logic [IDXW-1:0]  idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NSTEP - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int STEP_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fire
);
    localparam int CW = (STEP_LAT > 1) ? $clog2(STEP_LAT) : 1;

    logic          active;
    logic [CW-1:0] cnt;

    assign fire = active && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= CW'(STEP_LAT - 1);
        end else if (fire) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/vt_guard.sv
module vt_guard #(
    parameter int VT_PERIOD = 16,
    parameter int VT_UPD    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inhibit,
    output logic updating,
    output logic stopped
);
    localparam int TW = (VT_PERIOD > 1) ? $clog2(VT_PERIOD) : 1;
    localparam int UW = $clog2(VT_UPD + 1);

    logic [TW-1:0] tick;
    logic [UW-1:0] upd_cnt;

    assign updating = (upd_cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick    <= '0;
            upd_cnt <= '0;
            stopped <= 1'b0;
        end else begin
            if (updating) begin
                upd_cnt <= upd_cnt - 1'b1;
            end else if (!inhibit) begin
                if (tick == TW'(VT_PERIOD - 1)) begin
                    tick    <= '0;
                    upd_cnt <= UW'(VT_UPD);
                end else begin
                    tick <= tick + 1'b1;
                end
            end
            stopped <= inhibit && (upd_cnt <= UW'(1));
        end
    end
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
    import phy_init_seq_pkg::*;
#(
    parameter int STEP_LAT  = 4,
    parameter int VT_PERIOD = 16,
    parameter int VT_UPD    = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_we,
    input  logic [31:0] trig_data,
    input  logic [10:0] err_inject,
    input  logic        vt_inhibit,
    output logic [31:0] status,
    output logic        busy,
    output logic        vt_stop,
    output logic        vt_updating
);
    seq_state_t       st, st_nx;
    logic [NSTEP-1:0] pend, done_f, req_w;
    logic [NERR-1:0]  err_f;
    logic             all_done, byp_all, byp_zq;
    logic [IDXW-1:0]  cur, pick_idx;
    logic             pick_any, byp_hit, tmr_start, tmr_fire, accept;
    logic             unused_trig;

    assign unused_trig = ^{trig_data[3:2], trig_data[29:16]};
    assign req_w       = decode_req(trig_data);
    assign accept      = trig_we && trig_data[0] && (st == SQ_IDLE);
    assign byp_hit     = byp_all || (byp_zq && pick_idx == ST_ZCAL);
    assign tmr_start   = (st == SQ_SCAN) && pick_any && !byp_hit;

    step_pick u_pick (.req(pend), .any(pick_any), .idx(pick_idx));

    step_timer #(.STEP_LAT(STEP_LAT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .fire(tmr_fire)
    );

    vt_guard #(.VT_PERIOD(VT_PERIOD), .VT_UPD(VT_UPD)) u_vt (
        .clk(clk), .rst_n(rst_n), .inhibit(vt_inhibit),
        .updating(vt_updating), .stopped(vt_stop)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            SQ_IDLE: if (accept) st_nx = SQ_SCAN;
            SQ_SCAN: begin
                if (!pick_any)    st_nx = SQ_IDLE;
                else if (byp_hit) st_nx = SQ_SCAN;
                else              st_nx = SQ_RUN;
            end
            SQ_RUN:  if (tmr_fire) st_nx = SQ_SCAN;
            default: st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            done_f   <= '0;
            err_f    <= '0;
            all_done <= 1'b0;
            byp_all  <= 1'b0;
            byp_zq   <= 1'b0;
            cur      <= '0;
        end else begin
            if (accept) begin
                pend     <= req_w;
                byp_all  <= trig_data[31];
                byp_zq   <= trig_data[30];
                all_done <= 1'b0;
                done_f   <= done_f & ~req_w;
                err_f    <= err_f & ~err_mask(req_w);
            end
            if (st == SQ_SCAN) begin
                if (!pick_any) begin
                    all_done <= 1'b1;
                end else if (byp_hit) begin
                    done_f[pick_idx] <= 1'b1;
                    pend[pick_idx]   <= 1'b0;
                end else begin
                    cur <= pick_idx;
                end
            end
            if (st == SQ_RUN && tmr_fire) begin
                done_f[cur] <= 1'b1;
                pend[cur]   <= 1'b0;
                if (cur == ST_ZCAL)
                    err_f[0] <= err_inject[cur];
                else if (cur >= ST_WL)
                    err_f[3'(cur - 4'd3)] <= err_inject[cur];
            end
        end
    end

    assign busy   = (st != SQ_IDLE);
    assign status = {4'b0, err_f, 8'b0, done_f, all_done};
endmodule

// File: rtl/phy_init_seq_chk.sv
module phy_init_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] status,
    input logic        busy,
    input logic        vt_inhibit,
    input logic        vt_stop,
    input logic        vt_updating
);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !busy);

    p_fall_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> status[0]);

    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !status[0]);

    p_err_has_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[20] && !status[3]) && ((status[27:21] & ~status[11:5]) == 7'd0));

    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vt_stop |-> !vt_updating);

    p_no_upd_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vt_updating) |-> $past(!vt_inhibit));

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vt_inhibit |=> !vt_stop);
endmodule

bind phy_init_seq phy_init_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .status(status), .busy(busy),
    .vt_inhibit(vt_inhibit), .vt_stop(vt_stop), .vt_updating(vt_updating)
);

// File: tb/tb_phy_init_seq.sv
module tb_phy_init_seq;
    localparam int LAT  = 4;
    localparam int NVEC = 9;

    localparam logic [31:0] VEC_TRIG [NVEC] = '{
        32'h0000_FFF3, 32'h0000_FE01, 32'h0000_0A01, 32'h0000_0003,
        32'h4000_0003, 32'h8000_0203, 32'h0000_0041, 32'h0000_0081,
        32'h0000_0001
    };
    localparam logic [10:0] VEC_INJ [NVEC] = '{
        11'h000, 11'h7FF, 11'h040, 11'h004,
        11'h004, 11'h7FF, 11'h001, 11'h008,
        11'h000
    };

    logic        clk = 1'b0, rst_n = 1'b0, trig_we = 1'b0, vt_inhibit = 1'b0;
    logic [31:0] trig_data = '0;
    logic [10:0] err_inject = '0;
    logic [31:0] status;
    logic        busy, vt_stop, vt_updating;
    logic [31:0] expv = '0;
    int          total = 0, fails = 0;

    always #10 clk = ~clk;

    phy_init_seq #(.STEP_LAT(LAT), .VT_PERIOD(16), .VT_UPD(3)) dut (
        .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_data(trig_data),
        .err_inject(err_inject), .vt_inhibit(vt_inhibit), .status(status),
        .busy(busy), .vt_stop(vt_stop), .vt_updating(vt_updating)
    );

    // Bench model of the status word, built from R2, R4, R5, R7..R9.
    function automatic logic [31:0] model(input logic [31:0] prev, input logic [31:0] t,
                                          input logic [10:0] inj);
        logic [10:0] r;
        logic [31:0] s;
        if (!t[0]) return prev;
        r[0] = t[4] | t[6]; r[1] = t[5]; r[2] = t[1]; r[3] = t[7] | t[8];
        r[10:4] = t[15:9];
        s = prev;
        for (int k = 0; k < 11; k++) if (r[k]) s[1+k] = 1'b1;
        if (r[2]) s[20] = !t[31] && !t[30] && inj[2];
        for (int k = 4; k < 11; k++) if (r[k]) s[17+k] = !t[31] && inj[k];
        s[0] = 1'b1;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] t);
        @(negedge clk);
        trig_we = 1'b1; trig_data = t;
        @(negedge clk);
        trig_we = 1'b0; trig_data = '0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int first_wl, first_qsg, hits;
        logic stop_during_upd;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 status", status, 32'h0);
        chk("R12 busy", {31'b0, busy}, 32'h0);
        chk("R12 vt_stop", {31'b0, vt_stop}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5 R7 R8 R9 R6: vector walk
        for (int v = 0; v < NVEC; v++) begin
            err_inject = VEC_INJ[v];
            wr(VEC_TRIG[v]);
            wait_idle();
            expv = model(expv, VEC_TRIG[v], VEC_INJ[v]);
            chk($sformatf("R2/R5/R7/R8/R9 vec %0d status", v), status, expv);
        end

        // R1: bit 0 clear is ignored
        err_inject = 11'h7FF;
        wr(32'h0000_FFFE);
        @(negedge clk);
        chk("R1 no start busy", {31'b0, busy}, 32'h0);
        chk("R1 no start status", status, expv);

        // R3 order and timing, R1 write during busy ignored, R6 completion
        err_inject = 11'h004;
        wr(32'h0000_0601);
        first_wl = -1; first_qsg = -1;
        for (int c = 1; c < 100 && !status[0]; c++) begin
            @(negedge clk);
            if (c == 2) begin trig_we = 1'b1; trig_data = 32'h0000_0003; end
            if (c == 3) begin trig_we = 1'b0; trig_data = '0; end
            if (status[5] && first_wl < 0) first_wl = c;
            if (status[6] && first_qsg < 0) first_qsg = c;
        end
        chk("R3 first done cycle", first_wl, LAT + 1);
        chk("R3 second done cycle", first_qsg, 2 * (LAT + 1));
        repeat (3) @(negedge clk);
        expv = model(expv, 32'h0000_0601, 11'h004);
        chk("R1 busy write ignored status", status, expv);
        chk("R6 idle after done", {31'b0, busy}, 32'h0);

        // R10 inhibit during an update
        hits = 0;
        for (int n = 0; n < 60 && !vt_updating; n++) @(negedge clk);
        vt_inhibit = 1'b1;
        stop_during_upd = 1'b0;
        for (int n = 0; n < 20 && !vt_stop; n++) begin
            @(negedge clk);
            if (vt_stop && vt_updating) stop_during_upd = 1'b1;
        end
        chk("R10 stop reached", {31'b0, vt_stop}, 32'h1);
        chk("R10 stop not during update", {31'b0, stop_during_upd}, 32'h0);
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (vt_updating) hits++;
        end
        chk("R10 no update while inhibited", hits, 0);
        vt_inhibit = 1'b0;
        @(negedge clk);
        chk("R11 stop released", {31'b0, vt_stop}, 32'h0);

        // R10 inhibit while quiet: stop after one edge
        for (int n = 0; n < 60 && vt_updating; n++) @(negedge clk);
        vt_inhibit = 1'b1;
        @(negedge clk);
        chk("R10 quiet stop", {31'b0, vt_stop}, 32'h1);
        vt_inhibit = 1'b0;
        @(negedge clk);
        chk("R11 quiet release", {31'b0, vt_stop}, 32'h0);

        finish_run();
    end
endmodule